// File: doc/BRIEF.md
# Complementary PWM Carrier Generator with Dead-Time and Minimum-Pulse Filtering

This block drives one half-bridge leg: it turns a signed modulation sample into a top-arm and a bottom-arm gate signal. A power-of-two prescaler divides the master clock into ticks. A 512-step carrier counter advances once per tick. The sample is latched once per carrier period and compared against the counter, which gives an ideal two-level waveform.

That ideal waveform then passes through two shaping stages. A minimum-width filter removes any ideal pulse that is too short to switch cleanly. A turn-on delay keeps each arm low for a programmable number of ticks after the opposite arm has turned off, so both arms never conduct together. The delay shortens every surviving pulse, so the narrowest pulse that can appear at a pin is the filter width minus the delay.

A counter-reset control forces a fixed half-duty waveform. This is the waveform in effect after power-up, while the configuration is still all zero. A trip input shuts both arms off at once, and they stay off until the next reset. All codes come in on plain input ports. The host bus, the waveform table and amplitude scaling are built elsewhere.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: The carrier period is 512·2^S master clocks, where S is the 3-bit carrier-select value. S = 2 gives 2048 clocks, which is 6 kHz from a 12.288 MHz clock.
- R2: The 9-bit two's-complement sample s sets a threshold of s + 256. The ideal top signal is high for the first (s + 256) ticks of each period and low for the rest. The ideal bottom signal is its complement.
- R3: The sample is taken once, at the start of each carrier period. A change made in the middle of a period first affects the following period.
- R4: The turn-on delay is D = 64 − c ticks for the 6-bit delay code c, where code 0 gives 64 and code 48 gives 16. An arm rises only D ticks after the other arm has fallen, and both outputs are never high together.
- R5: The filter width is W = 128 − d ticks for the 7-bit deletion code d, where code 82 gives 46. An ideal high or low pulse shorter than W ticks is dropped, and the outputs keep their previous state. Every surviving edge is delayed by W ticks.
- R6: An ideal pulse exactly W ticks wide survives and appears at its output (W − D) ticks wide. This is the narrowest possible visible pulse.
- R7: While counter reset is high, the threshold is held at 256, so the waveform is a fixed 50 % whatever the sample.
- R8: A clock edge with rst_n low drives both outputs low from the next cycle and clears all internal state.
- R9: A clock edge with trip high drives both outputs low from the next cycle. They stay low after trip falls, until rst_n is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trip_i | input | 1 | Fault shutdown request, latched |
| cnt_rst_i | input | 1 | Forces the 50 % waveform while high |
| carr_sel_i | input | 3 | Prescale exponent S, division 2^S |
| dly_code_i | input | 6 | Turn-on delay code, D = 64 − code |
| del_code_i | input | 7 | Minimum-pulse code, W = 128 − code |
| mod_i | input | 9 | Signed modulation sample |
| top_o | output | 1 | Top-arm drive |
| bot_o | output | 1 | Bottom-arm drive |

## Verification
The outputs are registered, so trip and reset take effect one clock after the edge that samples them. The bench checks them at the following falling edge. An ideal edge reaches a pin W ticks later, and a rising edge waits a further D ticks. A new sample waits for the next period boundary. These fixed latencies are equal on both edges of a pulse, so the bench measures widths, periods and the gap between the two arms as distances between observed edges, taken several periods after each configuration change. Each measured value is compared with the value derived from the requirement.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;

    localparam int SEL_W_DEF  = 3;
    localparam int DLY_W_DEF  = 6;
    localparam int DEL_W_DEF  = 7;
    localparam int STEP_W_DEF = 9;

    typedef enum logic {
        PH_DEAD  = 1'b0,
        PH_DRIVE = 1'b1
    } phase_e;

    typedef struct packed {
        logic top;
        logic bot;
    } drive_t;

    // complement-coded count: full range minus code, code zero selects the maximum
    function automatic int code_to_ticks(input int width, input int code);
        return (1 << width) - code;
    endfunction

endpackage

// File: rtl/pwmdt_prescaler.sv
module pwmdt_prescaler #(
    parameter int SEL_W = pwmdt_pkg::SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb lim = DIV_W'((32'd1 << sel) - 32'd1);

    // >= keeps the count bounded if the select shrinks mid-count
    assign tick = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (tick)  cnt_q <= '0;
        else            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/pwmdt_carrier.sv
module pwmdt_carrier #(
    parameter int STEP_W = pwmdt_pkg::STEP_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     hold_mid,
    input  logic signed [STEP_W-1:0] sample,
    output logic                     ideal
);
    localparam logic [STEP_W-1:0] MID  = STEP_W'(1) << (STEP_W - 1);
    localparam logic [STEP_W-1:0] LAST = '1;

    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] thr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            thr_q <= MID;
        end else begin
            if (tick) cnt_q <= cnt_q + STEP_W'(1);
            if (hold_mid)
                thr_q <= MID;
            else if (tick && cnt_q == LAST)
                // offset-binary: adding half range flips the sign bit
                thr_q <= {~sample[STEP_W-1], sample[STEP_W-2:0]};
        end
    end

    assign ideal = (cnt_q < thr_q);
endmodule

// File: rtl/pwmdt_shaper.sv
module pwmdt_shaper
    import pwmdt_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEF,
    parameter int DEL_W = DEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ideal,
    input  logic [DLY_W-1:0] dly_code,
    input  logic [DEL_W-1:0] del_code,
    output drive_t           drv
);
    localparam logic [DLY_W:0] DLY_ONE = 1;
    localparam logic [DEL_W:0] DEL_ONE = 1;

    logic [DLY_W:0] dly_ticks;
    logic [DEL_W:0] del_ticks;
    logic           filt_q;
    logic [DEL_W:0] run_q;
    logic [DLY_W:0] dead_q;
    phase_e         ph_q;

    always_comb begin
        dly_ticks = (DLY_W+1)'(code_to_ticks(DLY_W, int'(dly_code)));
        del_ticks = (DEL_W+1)'(code_to_ticks(DEL_W, int'(del_code)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
            dead_q <= '0;
            ph_q   <= PH_DEAD;
        end else begin
            if (ideal == filt_q) run_q <= '0;
            if (tick) begin
                // turn-on delay counts ticks since the last switch
                if (ph_q == PH_DEAD) begin
                    if (dead_q + DLY_ONE >= dly_ticks) ph_q <= PH_DRIVE;
                    else                               dead_q <= dead_q + DLY_ONE;
                end
                // filter: follow the ideal level only once it has held for the full width
                if (ideal != filt_q) begin
                    if (run_q + DEL_ONE >= del_ticks) begin
                        filt_q <= ideal;
                        run_q  <= '0;
                        dead_q <= '0;
                        ph_q   <= PH_DEAD;
                    end else begin
                        run_q <= run_q + DEL_ONE;
                    end
                end
            end
        end
    end

    always_comb begin
        drv.top = filt_q  && (ph_q == PH_DRIVE);
        drv.bot = !filt_q && (ph_q == PH_DRIVE);
    end
endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
    import pwmdt_pkg::*;
#(
    parameter int SEL_W  = SEL_W_DEF,
    parameter int DLY_W  = DLY_W_DEF,
    parameter int DEL_W  = DEL_W_DEF,
    parameter int STEP_W = STEP_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trip_i,
    input  logic                     cnt_rst_i,
    input  logic [SEL_W-1:0]         carr_sel_i,
    input  logic [DLY_W-1:0]         dly_code_i,
    input  logic [DEL_W-1:0]         del_code_i,
    input  logic signed [STEP_W-1:0] mod_i,
    output logic                     top_o,
    output logic                     bot_o
);
    logic   tick;
    logic   ideal;
    logic   trip_q;
    drive_t shaped;
    drive_t out_q;

    pwmdt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (carr_sel_i),
        .tick  (tick)
    );

    pwmdt_carrier #(.STEP_W(STEP_W)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold_mid (cnt_rst_i),
        .sample   (mod_i),
        .ideal    (ideal)
    );

    pwmdt_shaper #(.DLY_W(DLY_W), .DEL_W(DEL_W)) u_shp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ideal    (ideal),
        .dly_code (dly_code_i),
        .del_code (del_code_i),
        .drv      (shaped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      trip_q <= 1'b0;
        else if (trip_i) trip_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || trip_i || trip_q) out_q <= '0;
        else                            out_q <= shaped;
    end

    assign top_o = out_q.top;
    assign bot_o = out_q.bot;
endmodule

// File: rtl/pwmdt_checker.sv
module pwmdt_checker (
    input logic clk,
    input logic rst_n,
    input logic trip_i,
    input logic top_o,
    input logic bot_o
);
    logic trip_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)      trip_seen <= 1'b0;
        else if (trip_i) trip_seen <= 1'b1;
    end

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(top_o && bot_o));                                      // R4

    AST_RISE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_o) |-> $past(!bot_o));                         // R4

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!top_o && !bot_o));                          // R8

    AST_TRIP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> (!top_o && !bot_o));                          // R9

    AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        trip_seen |-> (!top_o && !bot_o));                       // R9
endmodule

bind pwm_deadtime_gen pwmdt_checker chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_i (trip_i),
    .top_o  (top_o),
    .bot_o  (bot_o)
);

// File: tb/pwm_deadtime_gen_tb.sv
module pwm_deadtime_gen_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trip = 1'b0;
    logic              cnt_rst = 1'b1;
    logic [2:0]        sel = 3'd2;
    logic [5:0]        dly = 6'd63;
    logic [6:0]        del = 7'd127;
    logic signed [8:0] mod = 9'sd0;
    logic              top, bot;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    pwm_deadtime_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_i     (trip),
        .cnt_rst_i  (cnt_rst),
        .carr_sel_i (sel),
        .dly_code_i (dly),
        .del_code_i (del),
        .mod_i      (mod),
        .top_o      (top),
        .bot_o      (bot)
    );

    function automatic logic sig(input bit use_bot);
        return use_bot ? bot : top;
    endfunction

    // driver side: queue the expected result
    task automatic expect_val(input string tag, input int v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        exp_q.push_back(e);
    endtask

    // monitor side: pop the oldest expectation and compare
    task automatic observe(input int act);
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (act != e.val) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.val);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(input bit b);
        while (sig(b))  @(negedge clk);
        while (!sig(b)) @(negedge clk);
    endtask

    task automatic meas_width(input bit b, output int w);
        wait_rise(b);
        w = 0;
        while (sig(b)) begin w++; @(negedge clk); end
    endtask

    task automatic meas_period(input bit b, output int p);
        wait_rise(b);
        p = 0;
        while (sig(b))  begin @(negedge clk); p++; end
        while (!sig(b)) begin @(negedge clk); p++; end
    endtask

    task automatic meas_gap(input bit from_bot, output int g);
        while (!sig(from_bot)) @(negedge clk);
        while (sig(from_bot))  @(negedge clk);
        g = 0;
        while (!sig(!from_bot)) begin @(negedge clk); g++; end
    endtask

    task automatic count_high(input bit b, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sig(b)) c++;
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        // R8: reset state
        wait_clk(4);
        expect_val("R8 top in reset", 0); observe(int'(top));
        expect_val("R8 bot in reset", 0); observe(int'(bot));

        // R7 / R1: counter reset, S=2, D=1, W=1, sample ignored
        mod   = 9'sd200;
        rst_n = 1'b1;
        wait_clk(3 * 2048);
        expect_val("R1 period S=2 (6 kHz at 12.288 MHz)", 2048);
        meas_period(1'b0, v); observe(v);
        expect_val("R7 top width at 50%", 1020);
        meas_width(1'b0, v); observe(v);
        expect_val("R7 bot width at 50%", 1020);
        meas_width(1'b1, v); observe(v);

        // R2: S=0, D=16 (code 48), W=1, threshold 384
        cnt_rst = 1'b0; sel = 3'd0; dly = 6'd48; del = 7'd127; mod = 9'sd128;
        wait_clk(3 * 512);
        expect_val("R2 top width thr 384", 368);
        meas_width(1'b0, v); observe(v);
        expect_val("R2 bot width thr 384", 112);
        meas_width(1'b1, v); observe(v);
        expect_val("R1 period S=0", 512);
        meas_period(1'b0, v); observe(v);

        // R3: change sample during a high pulse
        expect_val("R3 current period unchanged", 368);
        wait_rise(1'b0);
        v = 0;
        while (top) begin
            v++;
            if (v == 100) mod = 9'sd0;
            @(negedge clk);
        end
        observe(v);
        expect_val("R3 next period uses new sample", 240);
        meas_width(1'b0, v); observe(v);

        // R4: gap between arms, S=1, D=16 -> 32 clocks
        sel = 3'd1; mod = 9'sd128;
        wait_clk(3 * 1024);
        expect_val("R4 top fall to bot rise", 32);
        meas_gap(1'b0, v); observe(v);
        expect_val("R4 bot fall to top rise", 32);
        meas_gap(1'b1, v); observe(v);

        // R5 / R6: S=0, D=16, W=46 (code 82)
        sel = 3'd0; del = 7'd82; mod = -9'sd196;   // threshold 60
        wait_clk(3 * 512);
        expect_val("R5 surviving pulse thr 60", 44);
        meas_width(1'b0, v); observe(v);
        mod = -9'sd210;                             // threshold 46
        wait_clk(3 * 512);
        expect_val("R6 narrowest pulse thr 46", 30);
        meas_width(1'b0, v); observe(v);
        mod = -9'sd211;                             // threshold 45
        wait_clk(3 * 512);
        expect_val("R5 top dropped thr 45", 0);
        count_high(1'b0, 1024, v); observe(v);
        expect_val("R5 bot held high thr 45", 1024);
        count_high(1'b1, 1024, v); observe(v);
        mod = 9'sd244;                              // threshold 500
        wait_clk(3 * 512);
        expect_val("R5 bot dropped thr 500", 0);
        count_high(1'b1, 1024, v); observe(v);
        expect_val("R5 top held high thr 500", 1024);
        count_high(1'b0, 1024, v); observe(v);

        // R9: trip latches
        mod = 9'sd128;
        wait_clk(3 * 512);
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        expect_val("R9 top low after trip", 0); observe(int'(top));
        expect_val("R9 bot low after trip", 0); observe(int'(bot));
        expect_val("R9 top stays low", 0);
        count_high(1'b0, 2000, v); observe(v);
        expect_val("R9 bot stays low", 0);
        count_high(1'b1, 2000, v); observe(v);

        // R8: reset clears the trip and operation resumes
        rst_n = 1'b0;
        wait_clk(2);
        expect_val("R8 top low in reset", 0); observe(int'(top));
        rst_n = 1'b1;
        wait_clk(3 * 512);
        expect_val("R8 operation after reset", 368);
        meas_width(1'b0, v); observe(v);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule